// File: doc/BRIEF.md
# Open-Drain Two-Wire Bus Repeater

This block joins two segments of a two-wire serial bus, named side A and side B, so that each segment keeps its own load while devices on both segments see one logical bus. It holds one independent channel per wire: channel 0 carries the clock wire and channel 1 carries the data wire. For each side of each channel the block reads a sampled copy of the line and drives a pull-low enable. An open-drain pad outside the block turns that enable into a low on the wire. The block can pull a wire low or let it go. It never drives a wire high.

When a device pulls one side low, the channel pulls the other side low. Analog repeaters use a level offset to tell their own low from a device's low. This block uses a direction state per channel instead. The channel remembers which side started the low and ignores the echo of its own drive. When the originating side releases, the channel lets go of the far side and waits through a settle window. It then samples the far side again. A device still holding the far side low at that point reverses the channel, so an acknowledge, a lost arbitration or a clock stretch reaches the originating side.

All line inputs and the enable pass through two-flop synchronizers. There is no data stream at the edge of the block, so every pin is plain control and status without a handshake.

Top module: `odr_repeater`

## Requirements
- R1: While reset is asserted, and after reset until a line is sampled low, every pull-low output is 0.
- R2: With the repeater enabled and a channel idle, a low on side A sets that channel's side-B pull exactly 3 clock edges after the low is first sampled. The side-A pull stays 0.
- R3: With the repeater enabled and a channel idle, a low on side B sets that channel's side-A pull exactly 3 clock edges after the low is first sampled. The side-B pull stays 0.
- R4: When the originating side returns high, the far-side pull clears exactly 3 clock edges later.
- R5: After the far-side pull clears, both pulls of that channel stay 0 for HOLD_CYC+2 clock edges (5 with defaults). The far side is not sampled during this window.
- R6: If the far side is still low at the end of that window, the channel reverses direction. The originating side is pulled low starting at edge HOLD_CYC+2 after the far pull cleared. This carries acknowledges and clock stretching back.
- R7: No lock-up occurs. Once every device on both sides has released a channel, both of its pulls are 0 and both lines are high within 12 clock edges.
- R8: If both sides of an idle channel are sampled low in the same cycle, side A wins: the side-B pull is set and the side-A pull stays 0.
- R9: When the enable input is 0, every pull clears within 3 clock edges, and lows on either side pass nowhere while it stays 0.
- R10: The channels are independent. Activity on one channel never sets a pull on the other.
- R11: A channel never asserts both of its pulls in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rpt_en | input | 1 | Repeater enable, active high, synchronized inside the block |
| a_line_i | input | NUM_CH | Sampled level of each side-A wire (bit 0 clock, bit 1 data) |
| b_line_i | input | NUM_CH | Sampled level of each side-B wire (bit 0 clock, bit 1 data) |
| a_pull_o | output | NUM_CH | Pull-low enable for each side-A pad, 1 means pull low |
| b_pull_o | output | NUM_CH | Pull-low enable for each side-B pad, 1 means pull low |

## Verification
The hardest case to reach from the ports is a reversal. This happens when a far-side device is still low exactly when the settle window closes, so the low has to travel back to the side that started it. The bench models each wire as a wired-AND of the device level and the repeater pull. It then brings up a far-side device low while the channel is still repeating, or during the settle window, and releases the originating device. This covers acknowledge, stretching from either side and ties. The bench repeats the case at random offsets and in a random release order, and after each episode it checks that every wire has returned high.

// File: rtl/odr_pkg.sv
package odr_pkg;

  // Direction state of one repeater channel.
  typedef enum logic [1:0] {
    CH_IDLE   = 2'd0,   // nobody holds the wire, both pulls released
    CH_A_DRV  = 2'd1,   // side A started the low, block pulls side B
    CH_B_DRV  = 2'd2,   // side B started the low, block pulls side A
    CH_SETTLE = 2'd3    // originator released, far side left to rise
  } ch_state_e;

  // Number of synchronizer flops on every input.
  localparam int unsigned SYNC_DEPTH = 2;

endpackage

// File: rtl/odr_sync.sv
module odr_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= {STAGES{{WIDTH{RST_VAL}}}};
        else        stage_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= {STAGES{{WIDTH{RST_VAL}}}};
        else        stage_q <= {stage_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/odr_settle_timer.sv
module odr_settle_timer #(
  parameter int unsigned TICKS = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic expired_o
);

  localparam int unsigned CW = (TICKS < 2) ? 1 : $clog2(TICKS + 1);

  logic [CW-1:0] cnt_q;

  // Loaded on entry to the settle state, counts down to zero and rests there.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (start_i)         cnt_q <= CW'(TICKS - 1);
    else if (cnt_q != '0)     cnt_q <= cnt_q - CW'(1);
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/odr_channel.sv
module odr_channel
  import odr_pkg::*;
#(
  parameter int unsigned SETTLE = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_s_i,
  input  logic a_s_i,
  input  logic b_s_i,
  output logic a_pull_o,
  output logic b_pull_o
);

  ch_state_e state_q, state_d;
  logic      settle_start;
  logic      settle_done;

  odr_settle_timer #(.TICKS(SETTLE)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (settle_start),
    .expired_o(settle_done)
  );

  // Choose a new direction from sampled lines; side A has priority on a tie.
  function automatic ch_state_e pick_dir(input logic a_lvl, input logic b_lvl);
    if (!a_lvl)      return CH_A_DRV;
    else if (!b_lvl) return CH_B_DRV;
    else             return CH_IDLE;
  endfunction

  always_comb begin
    state_d      = state_q;
    settle_start = 1'b0;
    unique case (state_q)
      CH_IDLE: begin
        if (en_s_i) state_d = pick_dir(a_s_i, b_s_i);
      end
      CH_A_DRV: begin
        // Side B is our own echo here: only side A decides the exit.
        if (!en_s_i) begin
          state_d = CH_IDLE;
        end else if (a_s_i) begin
          state_d      = CH_SETTLE;
          settle_start = 1'b1;
        end
      end
      CH_B_DRV: begin
        if (!en_s_i) begin
          state_d = CH_IDLE;
        end else if (b_s_i) begin
          state_d      = CH_SETTLE;
          settle_start = 1'b1;
        end
      end
      CH_SETTLE: begin
        if (!en_s_i)          state_d = CH_IDLE;
        else if (settle_done) state_d = pick_dir(a_s_i, b_s_i);
      end
      default: state_d = CH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= CH_IDLE;
    else        state_q <= state_d;
  end

  assign b_pull_o = (state_q == CH_A_DRV);
  assign a_pull_o = (state_q == CH_B_DRV);

endmodule

// File: rtl/odr_repeater.sv
module odr_repeater
  import odr_pkg::*;
#(
  parameter int unsigned NUM_CH   = 2,
  parameter int unsigned HOLD_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rpt_en,
  input  logic [NUM_CH-1:0] a_line_i,
  input  logic [NUM_CH-1:0] b_line_i,
  output logic [NUM_CH-1:0] a_pull_o,
  output logic [NUM_CH-1:0] b_pull_o
);

  // HOLD_CYC is meant to lie in 2..4; the synchronizer depth is added so the
  // far side is read only after its release has crossed the sync chain.
  localparam int unsigned HOLD_EFF = (HOLD_CYC < 2) ? 2 : ((HOLD_CYC > 4) ? 4 : HOLD_CYC);
  localparam int unsigned SETTLE   = HOLD_EFF + SYNC_DEPTH;

  logic [NUM_CH-1:0] a_sync;
  logic [NUM_CH-1:0] b_sync;
  logic              en_sync;

  odr_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_DEPTH), .RST_VAL(1'b1)) u_sync_a (
    .clk(clk), .rst_n(rst_n), .d_i(a_line_i), .q_o(a_sync)
  );

  odr_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_DEPTH), .RST_VAL(1'b1)) u_sync_b (
    .clk(clk), .rst_n(rst_n), .d_i(b_line_i), .q_o(b_sync)
  );

  odr_sync #(.WIDTH(1), .STAGES(SYNC_DEPTH), .RST_VAL(1'b0)) u_sync_en (
    .clk(clk), .rst_n(rst_n), .d_i(rpt_en), .q_o(en_sync)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      odr_channel #(.SETTLE(SETTLE)) u_channel (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_s_i  (en_sync),
        .a_s_i   (a_sync[c]),
        .b_s_i   (b_sync[c]),
        .a_pull_o(a_pull_o[c]),
        .b_pull_o(b_pull_o[c])
      );
    end
  endgenerate

endmodule

// File: rtl/odr_repeater_chk.sv
module odr_repeater_chk #(
  parameter int unsigned NUM_CH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rpt_en,
  input logic [NUM_CH-1:0] a_line_i,
  input logic [NUM_CH-1:0] b_line_i,
  input logic [NUM_CH-1:0] a_pull_o,
  input logic [NUM_CH-1:0] b_pull_o
);

  logic [2:0] cyc_q;      // edges since reset, saturating
  logic [2:0] en_low_q;   // consecutive sampled low enables, saturating

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q    <= '0;
      en_low_q <= '0;
    end else begin
      if (cyc_q != 3'd7) cyc_q <= cyc_q + 3'd1;
      if (rpt_en)                en_low_q <= '0;
      else if (en_low_q != 3'd7) en_low_q <= en_low_q + 3'd1;
    end
  end

  wire hist_ok = (cyc_q >= 3'd4);

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
      // R1
      reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (!a_pull_o[c] && !b_pull_o[c]));

      // R2
      b_pull_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ok && $rose(b_pull_o[c])) |-> (!$past(a_line_i[c], 3) && $past(rpt_en, 3)));

      // R3
      a_pull_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ok && $rose(a_pull_o[c])) |-> (!$past(b_line_i[c], 3) && $past(rpt_en, 3)));

      // R4
      b_release_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ok && $fell(b_pull_o[c])) |-> ($past(a_line_i[c], 3) || !$past(rpt_en, 3)));

      // R5
      settle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(b_pull_o[c]) |=> (!a_pull_o[c] && !b_pull_o[c]));

      // R9
      disable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_low_q >= 3'd3) |-> (!a_pull_o[c] && !b_pull_o[c]));
    end
  endgenerate

endmodule

bind odr_repeater odr_repeater_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rpt_en  (rpt_en),
  .a_line_i(a_line_i),
  .b_line_i(b_line_i),
  .a_pull_o(a_pull_o),
  .b_pull_o(b_pull_o)
);

// File: tb/odr_repeater_bench.sv
`timescale 1ns/1ps
module odr_repeater_bench;

  localparam int NCH  = 2;
  localparam int HOLD = 3;
  localparam int SETL = HOLD + 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           rpt_en = 1'b0;
  logic [NCH-1:0] a_dev = '1;   // device level on side A, 0 = device pulls low
  logic [NCH-1:0] b_dev = '1;
  logic [NCH-1:0] a_line, b_line, a_pull, b_pull;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // Wired-AND wires: a line is low when a device or the repeater pulls it.
  assign a_line = a_dev & ~a_pull;
  assign b_line = b_dev & ~b_pull;

  always #10 clk = ~clk;

  odr_repeater #(.NUM_CH(NCH), .HOLD_CYC(HOLD)) u_odr_repeater (
    .clk     (clk),
    .rst_n   (rst_n),
    .rpt_en  (rpt_en),
    .a_line_i(a_line),
    .b_line_i(b_line),
    .a_pull_o(a_pull),
    .b_pull_o(b_pull)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Expected originating-side level after release: low only if the far device still holds.
  function automatic logic exp_orig_after(input logic far_still_low);
    return far_still_low ? 1'b0 : 1'b1;
  endfunction

  // Expected far-side level while the originator holds low and the repeater is on.
  function automatic logic exp_far_during(input logic enabled);
    return enabled ? 1'b0 : 1'b1;
  endfunction

  task automatic check_idle(input string req);
    for (int c = 0; c < NCH; c++) begin
      check(req, a_pull[c], 1'b0);
      check(req, b_pull[c], 1'b0);
      check(req, a_line[c], 1'b1);
      check(req, b_line[c], 1'b1);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int ch, oth, mode, hold_len;
    logic stretch, a_first;
    void'($urandom(32'd2718));

    // R1: quiet during reset
    step(3);
    check("R1 a_pull in reset", a_pull[0] | a_pull[1], 1'b0);
    check("R1 b_pull in reset", b_pull[0] | b_pull[1], 1'b0);
    rst_n = 1'b1;
    rpt_en = 1'b1;
    step(6);
    check_idle("R1 after reset");

    // R2: side A low reaches side B after exactly 3 edges
    a_dev[0] = 1'b0;
    step(2);
    check("R2 b_pull before latency", b_pull[0], 1'b0);
    step(1);
    check("R2 b_pull at latency", b_pull[0], 1'b1);
    check("R2 b_line low", b_line[0], 1'b0);
    check("R2 a_pull stays off", a_pull[0], 1'b0);
    check("R10 other channel quiet", a_pull[1] | b_pull[1], 1'b0);
    check("R11 not both pulls", a_pull[0] & b_pull[0], 1'b0);

    // R4 / R5: release, settle window, back to idle
    a_dev[0] = 1'b1;
    step(2);
    check("R4 b_pull held before latency", b_pull[0], 1'b1);
    step(1);
    check("R4 b_pull released", b_pull[0], 1'b0);
    step(SETL - 1);
    check("R5 a_pull quiet in settle", a_pull[0], 1'b0);
    check("R5 b_pull quiet in settle", b_pull[0], 1'b0);
    step(6);
    check_idle("R7 after simple transfer");

    // R5 / R6: far device grabs the wire during settle, reversal at its end
    a_dev[0] = 1'b0;
    step(3);
    a_dev[0] = 1'b1;
    step(3);
    b_dev[0] = 1'b0;
    step(SETL - 1);
    check("R5 far low ignored in settle", a_pull[0], 1'b0);
    step(1);
    check("R6 reversal pulls A", a_pull[0], 1'b1);
    check("R6 a_line low", a_line[0], exp_orig_after(1'b1));
    check("R11 not both pulls", a_pull[0] & b_pull[0], 1'b0);
    b_dev[0] = 1'b1;
    step(3);
    check("R4 a_pull released", a_pull[0], 1'b0);
    step(10);
    check_idle("R7 after reversal");

    // R3: side B originates on data channel
    b_dev[1] = 1'b0;
    step(2);
    check("R3 a_pull before latency", a_pull[1], 1'b0);
    step(1);
    check("R3 a_pull at latency", a_pull[1], 1'b1);
    check("R3 b_pull stays off", b_pull[1], 1'b0);
    check("R10 clock channel quiet", a_pull[0] | b_pull[0], 1'b0);
    b_dev[1] = 1'b1;
    step(12);
    check_idle("R7 after B transfer");

    // R8: tie, side A wins
    a_dev[1] = 1'b0;
    b_dev[1] = 1'b0;
    step(3);
    check("R8 tie b_pull", b_pull[1], 1'b1);
    check("R8 tie a_pull", a_pull[1], 1'b0);
    b_dev[1] = 1'b1;
    a_dev[1] = 1'b1;
    step(12);
    check_idle("R7 after tie");

    // R9: disabled repeater passes nothing
    rpt_en = 1'b0;
    step(3);
    a_dev[0] = 1'b0;
    b_dev[1] = 1'b0;
    step(8);
    check("R9 no pass while off b_pull", b_pull[0], 1'b0);
    check("R9 no pass while off a_pull", a_pull[1], 1'b0);
    check("R9 far line", b_line[0], exp_far_during(1'b0));
    a_dev[0] = 1'b1;
    b_dev[1] = 1'b1;
    rpt_en = 1'b1;
    step(4);

    // R9: disable while repeating
    a_dev[0] = 1'b0;
    step(4);
    check("R9 repeating before disable", b_pull[0], 1'b1);
    rpt_en = 1'b0;
    step(2);
    check("R9 pull still on", b_pull[0], 1'b1);
    step(1);
    check("R9 pull cleared by disable", b_pull[0], 1'b0);
    a_dev[0] = 1'b1;
    step(3);
    rpt_en = 1'b1;
    step(6);
    check_idle("R9 recovered");

    // Random episodes: originator, optional far-side stretch, random timing
    for (int it = 0; it < 60; it++) begin
      ch       = int'($urandom % 2);
      oth      = 1 - ch;
      mode     = int'($urandom % 3);   // 0: A starts, 1: B starts, 2: tie
      stretch  = 1'($urandom % 2);
      hold_len = 3 + int'($urandom % 18);
      a_first  = 1'($urandom % 2);
      if (mode == 0) begin
        a_dev[ch] = 1'b0;
        step(4);
        check("R2 random far low", b_line[ch], exp_far_during(1'b1));
        if (stretch) b_dev[ch] = 1'b0;
        step(hold_len);
        a_dev[ch] = 1'b1;
        step(SETL + 4);
        check("R6 random stretch to A", a_line[ch], exp_orig_after(stretch));
        b_dev[ch] = 1'b1;
      end else if (mode == 1) begin
        b_dev[ch] = 1'b0;
        step(4);
        check("R3 random far low", a_line[ch], exp_far_during(1'b1));
        if (stretch) a_dev[ch] = 1'b0;
        step(hold_len);
        b_dev[ch] = 1'b1;
        step(SETL + 4);
        check("R6 random stretch to B", b_line[ch], exp_orig_after(stretch));
        a_dev[ch] = 1'b1;
      end else begin
        a_dev[ch] = 1'b0;
        b_dev[ch] = 1'b0;
        step(3);
        check("R8 random tie", b_pull[ch], 1'b1);
        step(hold_len);
        if (a_first) begin
          a_dev[ch] = 1'b1;
          step(SETL + 4);
          check("R6 tie reversal", a_line[ch], exp_orig_after(1'b1));
          b_dev[ch] = 1'b1;
        end else begin
          b_dev[ch] = 1'b1;
          step(2);
          a_dev[ch] = 1'b1;
        end
      end
      check("R10 random other quiet", a_pull[oth] | b_pull[oth], 1'b0);
      check("R11 random exclusive", a_pull[ch] & b_pull[ch], 1'b0);
      step(12);
      check_idle("R7 random release");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule